// File: doc/BRIEF.md
# Prescaled Event Counter

This block divides a tick enable down with a programmable down-counting prescaler and counts the prescaler's wrap events in a 32-bit up-counter. Each tick enable moves the prescaler one step towards zero. Once it reads zero, the next tick reloads it from a stored reload value, and the event counter advances on that same tick. In steady state the counter therefore advances once every reload+1 ticks. A reload value of zero holds the prescaler at zero, so the counter then advances on every tick.

Software can write three values independently: the reload value, the live prescaler and the event counter. Both live values are always visible on the outputs. All pins are plain control and status pins. There is no streaming data path, so no valid/ready handshake and no back-pressure. A load is taken on the clock edge where its write enable is high.

Top module: `prescaled_event_counter`

## Requirements
- R1: On a tick (`tick_en`=1) with no prescaler or counter load, a nonzero prescaler decrements by one and the event counter holds.
- R2: On a tick with no such load and the prescaler at zero, the prescaler takes the stored reload value and the event counter increments by one in the same cycle. With reload 5 and start 7, successive ticks give 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5, and the counter rises on the 8th and 14th tick.
- R3: With a reload value of zero, a prescaler at zero stays at zero and the event counter increments on every tick.
- R4: Writing the reload value changes only the stored reload value and leaves the live prescaler and the counter untouched. A tick in the same cycle as a reload write uses the previous reload value.
- R5: `ps_load_we` sets the prescaler to `ps_load_val` and `cnt_load_we` sets the counter to `cnt_load_val` at the next edge. Counting then continues from the loaded values.
- R6: In a cycle where `ps_load_we` or `cnt_load_we` is high, the tick is discarded. Neither live value advances, and a register that is not loaded keeps its value.
- R7: The event counter wraps from 2^32-1 to 0.
- R8: Without a tick and without loads, both live values hold.
- R9: Reset (`rst_n` low) clears the prescaler, the counter and the reload value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescale tick enable, one step per high cycle |
| reload_we | input | 1 | Write enable for the reload value |
| reload_val | input | 32 | New reload value |
| ps_load_we | input | 1 | Write enable for the live prescaler |
| ps_load_val | input | 32 | Value loaded into the prescaler |
| cnt_load_we | input | 1 | Write enable for the event counter |
| cnt_load_val | input | 32 | Value loaded into the event counter |
| ps_value | output | 32 | Live prescaler value |
| cnt_value | output | 32 | Live event counter value |

## Verification
Every result is due one edge after its stimulus. A tick, load or reload write applied in a cycle shows on `ps_value` and `cnt_value` right after the next rising edge. A reload write shows only through the next reload event, at the earliest one edge after the prescaler has reached zero. The bench drives inputs just after the falling edge and advances its behavioural model at the rising edge. It compares both outputs at the following falling edge, so every comparison sees exactly one edge's worth of change. The reference sequence for reload 5 and start 7 is also checked tick by tick.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [1:0] {
    PS_HOLD   = 2'd0,
    PS_LOAD   = 2'd1,
    PS_DEC    = 2'd2,
    PS_RELOAD = 2'd3
  } ps_action_e;

  typedef enum logic [1:0] {
    EV_HOLD = 2'd0,
    EV_LOAD = 2'd1,
    EV_INC  = 2'd2
  } ev_action_e;
endpackage

// File: rtl/pec_reload_reg.sv
module pec_reload_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (wr_en) value <= wr_val;
  end

  // R4: the stored reload value moves only on a write
  p_reload_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(value));
endmodule

// File: rtl/pec_prescaler.sv
module pec_prescaler
  import pec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ps_action_e   act,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] value,
  output logic         at_zero
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] nxt;

  always_comb begin
    unique case (act)
      PS_LOAD:   nxt = load_val;
      PS_DEC:    nxt = value - ONE;
      PS_RELOAD: nxt = reload_val;
      default:   nxt = value;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end

  assign at_zero = (value == '0);

  // R1: a decrement step lowers the live value by exactly one
  p_dec_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act == PS_DEC) |=> (value == $past(value) - ONE));
  // R5: a load lands at the next edge
  p_load_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == PS_LOAD) |=> (value == $past(load_val)));
  // R8: no action, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act == PS_HOLD) |=> $stable(value));
endmodule

// File: rtl/pec_event_counter.sv
module pec_event_counter
  import pec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ev_action_e   act,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else begin
      unique case (act)
        EV_LOAD: value <= load_val;
        EV_INC:  value <= value + ONE;
        default: value <= value;
      endcase
    end
  end

  // R7: increment wraps modulo 2^W
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == EV_INC && value == '1) |=> (value == '0));
  // R5: counter load lands at the next edge
  p_cnt_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == EV_LOAD) |=> (value == $past(load_val)));
endmodule

// File: rtl/prescaled_event_counter.sv
module prescaled_event_counter
  import pec_pkg::*;
#(
  parameter int unsigned PS_W  = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reload_we,
  input  logic [PS_W-1:0]  reload_val,
  input  logic             ps_load_we,
  input  logic [PS_W-1:0]  ps_load_val,
  input  logic             cnt_load_we,
  input  logic [CNT_W-1:0] cnt_load_val,
  output logic [PS_W-1:0]  ps_value,
  output logic [CNT_W-1:0] cnt_value
);
  logic [PS_W-1:0] reload_q;
  logic            ps_zero;
  logic            sw_load;
  logic            tick_ok;
  ps_action_e      ps_act;
  ev_action_e      ev_act;

  assign sw_load = ps_load_we | cnt_load_we;
  assign tick_ok = tick_en & ~sw_load;

  always_comb begin
    if (ps_load_we)              ps_act = PS_LOAD;
    else if (tick_ok && ps_zero) ps_act = PS_RELOAD;
    else if (tick_ok)            ps_act = PS_DEC;
    else                         ps_act = PS_HOLD;
  end

  always_comb begin
    if (cnt_load_we)             ev_act = EV_LOAD;
    else if (tick_ok && ps_zero) ev_act = EV_INC;
    else                         ev_act = EV_HOLD;
  end

  pec_reload_reg #(.W(PS_W)) u_reload (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reload_we),
    .wr_val (reload_val),
    .value  (reload_q)
  );

  pec_prescaler #(.W(PS_W)) u_ps (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (ps_act),
    .load_val   (ps_load_val),
    .reload_val (reload_q),
    .value      (ps_value),
    .at_zero    (ps_zero)
  );

  pec_event_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (ev_act),
    .load_val (cnt_load_val),
    .value    (cnt_value)
  );

  // R2: zero plus tick advances the counter by one
  p_wrap_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !sw_load && ps_value == '0) |=> (cnt_value == $past(cnt_value) + 1'b1));
  // R3: zero reload keeps the prescaler parked at zero
  p_zero_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ps_load_we && ps_value == '0 && reload_q == '0) |=> (ps_value == '0));
  // R6: a load discards the tick for the register not loaded
  p_tick_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_load_we && !cnt_load_we) |=> $stable(cnt_value));
  // R1: nonzero prescaler tick leaves the counter unchanged
  p_no_early_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_load_we && ps_value != '0) |=> $stable(cnt_value));
endmodule

// File: tb/prescaled_event_counter_bench.sv
module prescaled_event_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reload_we = 1'b0;
  logic [31:0] reload_val = '0;
  logic        ps_load_we = 1'b0;
  logic [31:0] ps_load_val = '0;
  logic        cnt_load_we = 1'b0;
  logic [31:0] cnt_load_val = '0;
  logic [31:0] ps_value;
  logic [31:0] cnt_value;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R9";

  logic [31:0] m_ps = '0, m_ev = '0, m_rl = '0;

  always #10 clk = ~clk;

  prescaled_event_counter u_prescaled_event_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .reload_we(reload_we), .reload_val(reload_val),
    .ps_load_we(ps_load_we), .ps_load_val(ps_load_val),
    .cnt_load_we(cnt_load_we), .cnt_load_val(cnt_load_val),
    .ps_value(ps_value), .cnt_value(cnt_value)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(tag, ps_value, m_ps, "prescaler");
    check(tag, cnt_value, m_ev, "counter");
  endtask

  // drive after negedge, model at posedge, compare at next negedge
  task automatic cyc(bit t, bit rw, logic [31:0] rd, bit pw, logic [31:0] pd,
                     bit ew, logic [31:0] ed);
    tick_en = t; reload_we = rw; reload_val = rd;
    ps_load_we = pw; ps_load_val = pd; cnt_load_we = ew; cnt_load_val = ed;
    @(posedge clk);
    if (!pw && !ew && t) begin
      if (m_ps == 0) begin m_ps = m_rl; m_ev = m_ev + 1; end
      else m_ps = m_ps - 1;
    end
    if (pw) m_ps = pd;
    if (ew) m_ev = ed;
    if (rw) m_rl = rd;
    @(negedge clk);
    tick_en = 0; reload_we = 0; ps_load_we = 0; cnt_load_we = 0;
    compare();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", ps_value, 32'h0, "prescaler in reset");
    check("R9", cnt_value, 32'h0, "counter in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R3: reload zero from reset, counter rises every tick
    tag = "R3"; ticks(5);
    check("R3", cnt_value, 32'd5, "counter after 5 ticks at reload 0");

    // R8: idle holds
    tag = "R8";
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0);

    // R2: reference sequence reload 5, start 7
    tag = "R5"; cyc(0, 1, 32'd5, 1, 32'd7, 1, 32'd0);
    tag = "R2";
    for (int k = 1; k <= 14; k++) begin
      cyc(1, 0, 0, 0, 0, 0, 0);
      check("R2", ps_value, (k <= 7) ? 32'(7 - k) : 32'(5 - ((k - 8) % 6)), "sequence step");
      check("R2", cnt_value, (k >= 14) ? 32'd2 : (k >= 8) ? 32'd1 : 32'd0, "sequence count");
    end

    // R4: reload write leaves live values; collision uses old reload
    tag = "R4"; cyc(0, 1, 32'd2, 0, 0, 0, 0);
    ticks(4);
    cyc(1, 1, 32'd9, 0, 0, 0, 0);
    ticks(12);

    // R1: long decrement
    tag = "R1"; cyc(0, 0, 0, 1, 32'd40, 0, 0);
    tag = "R1"; ticks(20);

    // R6: loads discard ticks
    tag = "R6";
    cyc(1, 0, 0, 1, 32'd3, 0, 0);
    cyc(1, 0, 0, 0, 0, 1, 32'd100);
    cyc(1, 0, 0, 1, 32'd0, 1, 32'd7);
    ticks(3);

    // R7: wrap
    tag = "R7";
    cyc(0, 1, 32'd0, 1, 32'd0, 1, 32'hFFFF_FFFF);
    cyc(1, 0, 0, 0, 0, 0, 0);
    check("R7", cnt_value, 32'h0, "counter wrap");
    ticks(3);

    // R5: mixed loads then counting, reload 1
    tag = "R5";
    cyc(0, 1, 32'd1, 1, 32'd2, 1, 32'h1234_0000);
    ticks(10);
    check("R5", cnt_value, 32'h1234_0004, "counter after loaded run");

    // R9: reset mid-run
    tag = "R9";
    @(negedge clk); rst_n = 1'b0;
    m_ps = 0; m_ev = 0; m_rl = 0;
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    ticks(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule